// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

This block is a memory-mapped timer with three independent 32-bit channels that count down. Software reaches it through a plain synchronous register port: an address, a write strobe, write data, and read data that follows the address in the same cycle. Each channel holds a reload value, a live count and a control word. A channel counts only while its run bit is set. Every count step comes from one tick source picked in the control word: one of five fixed divisions of the block clock, a one-cycle strobe from a real-time clock outside the block, or edges on an external clock pin. The pin edge can be rising, falling or both.

When a channel steps from zero, it reloads its reload value and latches an underflow flag. The flag can raise that channel's interrupt line. The last channel can also capture its live count into a read-only register on a rising edge of a capture pin. The capture sets its own flag, and that flag can raise the interrupt. The external clock pin and the capture pin may change at any time. Each passes through two synchronizing flip-flops before its edges are detected. One further register bit drives an output-enable level for a timer clock output that sits outside the block.

Top module: `dtu_top`

## Requirements
- R1: Register offsets, in bytes: 0x00 output control (bit 0 only), 0x04 run bits (bits 2:0), 0x2C capture value (read-only). Channel n uses 0x08+12n for the reload value, 0x0C+12n for the count and 0x10+12n for the control word. Any other offset reads zero and ignores writes. Control bits [5:0] can be written on every channel and bits [7:6] on channel 2 only. On channels 0 and 1, bits [7:6] and bit 9 read zero.
- R2: Run bit n lets channel n count. While the run bit is clear, the channel's count does not change except through a bus write.
- R3: Control bits [2:0] select the tick source: 0 gives clock/4, 1 gives clock/16, 2 gives clock/64, 3 gives clock/256, 4 gives clock/1024, 6 gives the real-time clock strobe, 7 gives the external pin, and 5 gives no ticks.
- R4: On a tick while running, a nonzero count decrements by one and a zero count reloads from the reload register. A bus write to the count takes priority over a tick in the same cycle.
- R5: A reload from zero sets the underflow flag (control bit 8). Writing 0 to the flag clears it. Writing 1 leaves it unchanged. A hardware set in the same cycle wins over a clear. The capture flag (bit 9) follows the same rules.
- R6: Interrupt line n is high when (bit 8 AND bit 5) of channel n is true. On channel 2 it is also high when (bit 9 AND bits [7:6] = 11) is true.
- R7: Control bits [4:3] select which external pin edges count as ticks: 00 rising, 01 falling, 10 both, 11 none. The pin passes through two synchronizer flops before edge detection.
- R8: When channel 2 has capture mode 10 or 11 (bits [7:6]), a synchronized rising edge on the capture pin copies channel 2's count into the capture register and sets bit 9. Mode 00 leaves both the capture register and bit 9 unchanged.
- R9: Capture mode 10 never raises an interrupt from the capture flag. Mode 11 does.
- R10: The output-enable pin equals bit 0 of the output-control register.
- R11: After reset, every register, flag, interrupt line and the output-enable pin are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the divided ticks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| rtc_strobe | input | 1 | One-cycle tick from the real-time clock, synchronous to clk |
| ext_clk_pin | input | 1 | External clock pin, asynchronous |
| cap_pin | input | 1 | Capture trigger pin, asynchronous |
| irq | output | 3 | Per-channel interrupt lines |
| clk_out_en | output | 1 | Output-enable level for the timer clock output |

## Verification
The assertions assume three things about the inputs: the real-time clock strobe is already synchronous to clk, only one register is written per cycle, and the bus address is driven stable during each cycle. The bench drives every input on the falling clock edge, so these assumptions always hold. The bench holds each level of the external pin and the capture pin for six cycles. That is longer than the synchronizer and edge-detector latency, so every edge is counted exactly once. Checks on the divided clock accept one tick of phase slack, because the free-running divider is not aligned to the moment a channel starts.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int NCH     = 3;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int NDIV    = 5;
  localparam int PRE_W   = 2 * NDIV;
  localparam int SYNC_N  = 2;

  localparam int OFF_OUTCTL  = 'h00;
  localparam int OFF_RUN     = 'h04;
  localparam int OFF_RELOAD  = 'h08;
  localparam int OFF_COUNT   = 'h0C;
  localparam int OFF_CTL     = 'h10;
  localparam int CH_STRIDE   = 'h0C;
  localparam int OFF_CAPTURE = 'h2C;

  localparam int BIT_UIE = 5;
  localparam int BIT_UF  = 8;
  localparam int BIT_CF  = 9;

  typedef enum logic [2:0] {
    SRC_D4 = 3'd0, SRC_D16 = 3'd1, SRC_D64 = 3'd2, SRC_D256 = 3'd3,
    SRC_D1024 = 3'd4, SRC_OFF = 3'd5, SRC_RTC = 3'd6, SRC_PIN = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0, EDGE_FALL = 2'd1, EDGE_BOTH = 2'd2, EDGE_NONE = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    CAP_OFF = 2'd0, CAP_RSVD = 2'd1, CAP_QUIET = 2'd2, CAP_IRQ = 2'd3
  } capm_e;
endpackage

// File: rtl/dtu_prescale.sv
module dtu_prescale #(
  parameter int NDIV  = 5,
  localparam int PRE_W = 2 * NDIV
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NDIV-1:0] div_tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // stage k pulses once every 4^(k+1) cycles
  for (genvar k = 0; k < NDIV; k++) begin : g_tap
    assign div_tick[k] = &pre_q[2*k+1:0];
  end
endmodule

// File: rtl/dtu_edge_sync.sv
module dtu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
  import dtu_pkg::*;
#(
  parameter int  W       = 32,
  parameter int  ND      = 5,
  parameter bit  HAS_CAP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [ND-1:0] div_tick,
  input  logic          rtc_tick,
  input  logic          pin_rise,
  input  logic          pin_fall,
  input  logic          cap_rise,
  input  logic          wr_reload,
  input  logic          wr_count,
  input  logic          wr_ctl,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  reload_o,
  output logic [W-1:0]  count_o,
  output logic [W-1:0]  ctl_o,
  output logic [W-1:0]  cap_o,
  output logic          tick_o,
  output logic          irq_o
);
  src_e        src_q;
  edge_e       edge_q;
  logic        uie_q;
  logic        uf_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] count_q;
  logic        pin_tick;
  logic [7:0]  src_vec;
  logic        step;
  logic        wrap;
  capm_e       capm;
  logic        cf;
  logic        cap_irq;

  always_comb begin
    unique case (edge_q)
      EDGE_RISE: pin_tick = pin_rise;
      EDGE_FALL: pin_tick = pin_fall;
      EDGE_BOTH: pin_tick = pin_rise | pin_fall;
      default:   pin_tick = 1'b0;
    endcase
  end

  // source code indexes this vector directly; code 5 is a constant zero
  assign src_vec = {pin_tick, rtc_tick, 1'b0, div_tick};
  assign tick_o  = src_vec[src_q];
  assign step    = run & tick_o & ~wr_count;
  assign wrap    = step & (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_count)  count_q  <= wdata;
      else if (step) count_q  <= wrap ? reload_q : count_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_D4;
      edge_q <= EDGE_RISE;
      uie_q  <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        src_q  <= src_e'(wdata[2:0]);
        edge_q <= edge_e'(wdata[4:3]);
        uie_q  <= wdata[BIT_UIE];
      end
      if (wrap)                          uf_q <= 1'b1;
      else if (wr_ctl && !wdata[BIT_UF]) uf_q <= 1'b0;
    end
  end

  if (HAS_CAP) begin : g_cap
    capm_e        capm_q;
    logic         cf_q;
    logic [W-1:0] cap_q;
    logic         grab;

    assign grab = cap_rise & capm_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        capm_q <= CAP_OFF;
        cf_q   <= 1'b0;
        cap_q  <= '0;
      end else begin
        if (wr_ctl) capm_q <= capm_e'(wdata[7:6]);
        if (grab) begin
          cap_q <= count_q;
          cf_q  <= 1'b1;
        end else if (wr_ctl && !wdata[BIT_CF]) begin
          cf_q <= 1'b0;
        end
      end
    end

    assign capm    = capm_q;
    assign cf      = cf_q;
    assign cap_o   = cap_q;
    assign cap_irq = cf_q & (capm_q == CAP_IRQ);
  end else begin : g_nocap
    logic unused_cap;
    assign unused_cap = cap_rise;
    assign capm    = CAP_OFF;
    assign cf      = 1'b0;
    assign cap_o   = '0;
    assign cap_irq = 1'b0;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctl_o    = {{(W-10){1'b0}}, cf, uf_q, capm, uie_q, edge_q, src_q};
  assign irq_o    = (uf_q & uie_q) | cap_irq;
endmodule

// File: rtl/dtu_top.sv
module dtu_top
  import dtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rtc_strobe,
  input  logic              ext_clk_pin,
  input  logic              cap_pin,
  output logic [NCH-1:0]    irq,
  output logic              clk_out_en
);
  localparam logic [ADDR_W-1:0] A_OUTCTL = ADDR_W'(OFF_OUTCTL);
  localparam logic [ADDR_W-1:0] A_RUN    = ADDR_W'(OFF_RUN);
  localparam logic [ADDR_W-1:0] A_CAP    = ADDR_W'(OFF_CAPTURE);

  logic                        outctl_q;
  logic [NCH-1:0]              run_q;
  logic [NDIV-1:0]             div_tick;
  logic                        pin_rise, pin_fall;
  logic                        cap_rise, cap_fall;
  logic [NCH-1:0][DATA_W-1:0]  reload_all, count_all, ctl_all, cap_all;
  logic [NCH-1:0]              tick_all;
  logic [NCH-1:0]              wr_reload, wr_count, wr_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outctl_q <= 1'b0;
      run_q    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_OUTCTL) outctl_q <= bus_wdata[0];
      if (bus_addr == A_RUN)    run_q    <= bus_wdata[NCH-1:0];
    end
  end

  dtu_prescale #(.NDIV(NDIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick)
  );

  dtu_edge_sync #(.STAGES(SYNC_N)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin), .rise(pin_rise), .fall(pin_fall)
  );

  dtu_edge_sync #(.STAGES(SYNC_N)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(cap_rise), .fall(cap_fall)
  );

  logic unused_cap_fall;
  assign unused_cap_fall = cap_fall;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_RL  = ADDR_W'(OFF_RELOAD + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_COUNT  + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL    + g * CH_STRIDE);

    assign wr_reload[g] = bus_wr && (bus_addr == A_RL);
    assign wr_count[g]  = bus_wr && (bus_addr == A_CNT);
    assign wr_ctl[g]    = bus_wr && (bus_addr == A_CTL);

    dtu_channel #(
      .W(DATA_W), .ND(NDIV), .HAS_CAP(g == NCH - 1)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run_q[g]),
      .div_tick(div_tick), .rtc_tick(rtc_strobe),
      .pin_rise(pin_rise), .pin_fall(pin_fall), .cap_rise(cap_rise),
      .wr_reload(wr_reload[g]), .wr_count(wr_count[g]), .wr_ctl(wr_ctl[g]),
      .wdata(bus_wdata),
      .reload_o(reload_all[g]), .count_o(count_all[g]), .ctl_o(ctl_all[g]),
      .cap_o(cap_all[g]), .tick_o(tick_all[g]), .irq_o(irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_OUTCTL) bus_rdata = {{(DATA_W-1){1'b0}}, outctl_q};
    if (bus_addr == A_RUN)    bus_rdata = {{(DATA_W-NCH){1'b0}}, run_q};
    if (bus_addr == A_CAP)    bus_rdata = cap_all[NCH-1];
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(OFF_RELOAD + c * CH_STRIDE)) bus_rdata = reload_all[c];
      if (bus_addr == ADDR_W'(OFF_COUNT  + c * CH_STRIDE)) bus_rdata = count_all[c];
      if (bus_addr == ADDR_W'(OFF_CTL    + c * CH_STRIDE)) bus_rdata = ctl_all[c];
    end
  end

  assign clk_out_en = outctl_q;
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker
  import dtu_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic [NCH-1:0]             run_q,
  input logic [NCH-1:0][DATA_W-1:0] reload_all,
  input logic [NCH-1:0][DATA_W-1:0] count_all,
  input logic [NCH-1:0][DATA_W-1:0] ctl_all,
  input logic [NCH-1:0][DATA_W-1:0] cap_all,
  input logic [NCH-1:0]             tick_all,
  input logic                       cap_rise,
  input logic [NCH-1:0]             irq
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(OFF_COUNT + g * CH_STRIDE));

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[g] && !cnt_wr) |=> $stable(count_all[g]));

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[g] && tick_all[g] && !cnt_wr && count_all[g] != '0)
        |=> count_all[g] == $past(count_all[g]) - DATA_W'(1));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[g] && tick_all[g] && !cnt_wr && count_all[g] == '0)
        |=> count_all[g] == $past(reload_all[g]));

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[g] && tick_all[g] && !cnt_wr && count_all[g] == '0)
        |=> ctl_all[g][BIT_UF]);

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_all[g][BIT_UF] && !ctl_all[g][BIT_CF]) |-> !irq[g]);
  end

  p_capture_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rise && ctl_all[NCH-1][7])
      |=> (cap_all[NCH-1] == $past(count_all[NCH-1])) && ctl_all[NCH-1][BIT_CF]);

  p_capture_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_all[NCH-1][7:6] == 2'b00) |=> $stable(cap_all[NCH-1]));
endmodule

bind dtu_top dtu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .run_q(run_q), .reload_all(reload_all), .count_all(count_all),
  .ctl_all(ctl_all), .cap_all(cap_all), .tick_all(tick_all),
  .cap_rise(cap_rise), .irq(irq)
);

// File: tb/sim_dtu_top.sv
`timescale 1ns/1ps
module sim_dtu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rtc_strobe = 1'b0;
  logic        ext_clk_pin = 1'b0;
  logic        cap_pin = 1'b0;
  logic [2:0]  irq;
  logic        clk_out_en;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dtu_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_strobe(rtc_strobe),
    .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin), .irq(irq), .clk_out_en(clk_out_en)
  );

  // {address, write data, expected readback}
  localparam logic [69:0] VECS [0:11] = '{
    {6'h08, 32'hDEADBEEF, 32'hDEADBEEF},
    {6'h14, 32'h00000077, 32'h00000077},
    {6'h20, 32'hCAFE0001, 32'hCAFE0001},
    {6'h0C, 32'h00000500, 32'h00000500},
    {6'h24, 32'h00000042, 32'h00000042},
    {6'h10, 32'h0000FFFF, 32'h0000003F},
    {6'h28, 32'h000000FF, 32'h000000FF},
    {6'h1C, 32'h000000C5, 32'h00000005},
    {6'h2C, 32'hFFFFFFFF, 32'h00000000},
    {6'h04, 32'h000000F8, 32'h00000000},
    {6'h00, 32'h000000FE, 32'h00000000},
    {6'h30, 32'h00001234, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_range(input string tag, input int got, input int lo, input int hi);
    nchk++;
    if (got < lo || got > hi) begin
      nfail++;
      $display("FAIL %s got=%0d exp=%0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic pulse_pin(input bit which);
    @(negedge clk);
    if (which) cap_pin = 1'b1; else ext_clk_pin = 1'b1;
    repeat (6) @(negedge clk);
    if (which) cap_pin = 1'b0; else ext_clk_pin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(6'h0C, v); chk("R11 count0 reset", v, 0);
    rd(6'h28, v); chk("R11 ctl2 reset", v, 0);
    rd(6'h04, v); chk("R11 run reset", v, 0);
    chk("R11 irq reset", {29'b0, irq}, 0);
    chk("R11 out enable reset", {31'b0, clk_out_en}, 0);

    // R1: register map and writable fields
    for (int i = 0; i < 12; i++) begin
      wr(VECS[i][69:64], VECS[i][63:32]);
      rd(VECS[i][69:64], v);
      chk($sformatf("R1 vec%0d", i), v, VECS[i][31:0]);
    end
    wr(6'h10, 0); wr(6'h1C, 0); wr(6'h28, 0);

    // R10: output-enable pin
    wr(6'h00, 1);
    chk("R10 out enable set", {31'b0, clk_out_en}, 1);
    wr(6'h00, 0);
    chk("R10 out enable clear", {31'b0, clk_out_en}, 0);

    // R3: divided-clock ratios, 8 ticks each
    for (int s = 0; s < 5; s++) begin
      int div;
      div = 4 << (2 * s);
      wr(6'h10, s);
      wr(6'h0C, 1000);
      wr(6'h04, 1);
      repeat (8 * div) @(negedge clk);
      wr(6'h04, 0);
      rd(6'h0C, v);
      chk_range($sformatf("R3 ratio code %0d ticks", s), 1000 - int'(v), 7, 9);
    end

    // R2: stopped channel holds
    rd(6'h0C, v);
    repeat (100) @(negedge clk);
    begin
      logic [31:0] v2;
      rd(6'h0C, v2);
      chk("R2 stopped count holds", v2, v);
    end

    // R3: source code 5 gives no ticks
    wr(6'h10, 5); wr(6'h0C, 50); wr(6'h04, 1);
    repeat (3000) @(negedge clk);
    rd(6'h0C, v); chk("R3 code 5 no ticks", v, 50);

    // R3: real-time clock strobe
    wr(6'h10, 6); wr(6'h0C, 50);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); rtc_strobe = 1'b1;
      @(negedge clk); rtc_strobe = 1'b0;
      repeat (3) @(negedge clk);
    end
    rd(6'h0C, v); chk("R3 rtc ticks", v, 45);
    wr(6'h04, 0);

    // R4/R5: reload from zero and flag
    wr(6'h10, 0); wr(6'h08, 2); wr(6'h0C, 1); wr(6'h04, 1);
    for (int k = 0; k < 100; k++) begin
      rd(6'h10, v);
      if (v[8]) break;
    end
    chk("R5 underflow flag set", {31'b0, v[8]}, 1);
    rd(6'h0C, v); chk("R4 reloaded count", v, 2);
    wr(6'h04, 0);
    chk("R6 irq low while enable clear", {31'b0, irq[0]}, 0);
    wr(6'h10, 32'h120);
    chk("R6 irq high with enable", {31'b0, irq[0]}, 1);
    rd(6'h10, v); chk("R5 write 1 keeps flag", {31'b0, v[8]}, 1);
    wr(6'h10, 32'h020);
    rd(6'h10, v); chk("R5 write 0 clears flag", {31'b0, v[8]}, 0);
    chk("R6 irq low after clear", {31'b0, irq[0]}, 0);

    // R4: count write while running
    wr(6'h10, 0); wr(6'h04, 1);
    wr(6'h0C, 32'h0000_9000);
    rd(6'h0C, v); chk_range("R4 count write while running", int'(v), 32'h9000 - 1, 32'h9000);
    wr(6'h04, 0);

    // R7: external pin edge modes on channel 1
    begin
      logic [31:0] exp_v [0:3];
      exp_v[0] = 97; exp_v[1] = 97; exp_v[2] = 94; exp_v[3] = 100;
      for (int m = 0; m < 4; m++) begin
        wr(6'h1C, 7 | (m << 3));
        wr(6'h18, 100);
        wr(6'h04, 2);
        for (int k = 0; k < 3; k++) pulse_pin(1'b0);
        wr(6'h04, 0);
        rd(6'h18, v);
        chk($sformatf("R7 edge mode %0d", m), v, exp_v[m]);
      end
    end

    // R8/R9: capture on channel 2 (stopped, so the count is fixed)
    wr(6'h28, 32'h080); wr(6'h24, 32'h1234_5678);
    pulse_pin(1'b1);
    rd(6'h2C, v); chk("R8 capture value", v, 32'h1234_5678);
    rd(6'h28, v); chk("R8 capture flag", {31'b0, v[9]}, 1);
    chk("R9 quiet mode no irq", {31'b0, irq[2]}, 0);
    wr(6'h28, 32'h2C0);
    chk("R9 irq mode raises irq", {31'b0, irq[2]}, 1);
    wr(6'h28, 32'h0C0);
    rd(6'h28, v); chk("R5 capture flag cleared", {31'b0, v[9]}, 0);
    chk("R9 irq low after clear", {31'b0, irq[2]}, 0);
    wr(6'h28, 32'h000); wr(6'h24, 32'h0000_ABCD);
    pulse_pin(1'b1);
    rd(6'h2C, v); chk("R8 mode off keeps capture", v, 32'h1234_5678);
    rd(6'h28, v); chk("R8 mode off no flag", {31'b0, v[9]}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule